// File: doc/BRIEF.md
# Buffered Serial Transmitter with Status Registers

This block sends characters on a single serial output line in asynchronous framing. Software writes characters through a small four-register port. Each character goes into a register-based FIFO, and from there into a frame shift register. The shift register takes the next character on its own as soon as the previous frame has finished. As a result, software can keep queuing characters while one is still on the line.

Each frame starts with one low start bit. The data bits follow, least significant first, then an optional parity bit, then one or two high stop bits. Every bit lasts a fixed, parameterised number of clock cycles. The character width is a parameter of 7, 8 or 9 bits.

Software uses the status register to see whether the FIFO can take more data and whether the line has gone quiet. The same register carries a sticky flag that records a character lost to a full FIFO. The level register gives the FIFO fill count. A break bit in the control register holds the line low and throws away everything still pending.

Top module: `sertx_core`

## Requirements
- R1: After reset the line is high. Status reads 3'b011 (ready, empty, no overrun). The level and control registers read 0.
- R2: The register port is word addressed with `reg_addr`: 0 write data (reads 0), 1 status, 2 control, 3 level (read only). A frame is one low start bit, then `DATA_W` data bits LSB first, then the parity bit if enabled, then the stop bits, which are high. Each bit lasts `CLKS_PER_BIT` cycles.
- R3: Control bits 2:1 select parity. 00 gives none, 01 gives even (total ones in data plus parity is even), 10 gives odd, and 11 gives none.
- R4: Control bit 3 selects two stop bits instead of one. Status bit 1 (empty) is high when the FIFO is empty and no frame is on the line. A character written to an idle block starts on the line one cycle after the write. Empty therefore returns `bits*CLKS_PER_BIT + 2` clock edges after the write edge, where the write edge counts as the first.
- R5: Status bit 0 (ready) is high exactly when the FIFO is not full. A data write while the FIFO is full is discarded, leaves the stored entries intact, and sets status bit 2 (overrun).
- R6: Overrun stays set once set. While it is set, every data write is discarded, even if the FIFO has room. Only a write of any value to the status register clears it.
- R7: The level register returns the FIFO entry count modulo `FIFO_DEPTH`, so a full FIFO reads 0.
- R8: While control bit 0 (break) is high, the line is held low. The FIFO and the frame in progress are flushed, and data writes are discarded. After break is released, the line idles high and nothing is sent.
- R9: Characters written while a frame is in progress are sent in write order with no loss, up to `FIFO_DEPTH` waiting behind the frame on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register (combinational) |
| txd | output | 1 | Serial output line |

## Verification
The bench builds the block with 8-bit characters, a FIFO depth of 4 and 4 clocks per bit. With a depth of 4, a handful of back-to-back writes fills the FIFO while one character is already in the shifter. That brings the full-FIFO drop, the sticky overrun and the wrap of the level register to zero within reach in a few dozen cycles. The short bit period keeps every frame under 50 cycles. That makes it cheap to measure exact frame lengths for all parity and stop settings, and to watch several idle frame times after a break to confirm that nothing leaks out.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_RSVD = 2'b11
  } par_mode_e;

  // Control register layout: bit 3 two stop bits, bits 2:1 parity, bit 0 break
  typedef struct packed {
    logic      two_stop;
    par_mode_e parity;
    logic      brk;
  } ctrl_t;

  localparam logic [1:0] ADDR_DATA  = 2'd0;
  localparam logic [1:0] ADDR_STAT  = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
  localparam logic [1:0] ADDR_LEVEL = 2'd3;

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     pop_data,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level
);

  logic [W-1:0]     mem_q [DEPTH];
  logic [LVL_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W:0]   cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign do_push = push & ~flush;
  assign do_pop  = pop & ~flush;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = wr_q + 1'b1;
      if (do_pop)  rd_d = rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data;
  end

  assign pop_data = mem_q[rd_q];
  assign full     = (cnt_q == (LVL_W+1)'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign level    = cnt_q[LVL_W-1:0];

  // R5: the write decode never offers data to a full store
  assert_push_not_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R9: the shifter only takes a character that is present
  assert_pop_not_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R8: a flush cycle leaves the store empty
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int CLKS_PER_BIT = 16,
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int W = 8,
  localparam int FW = W + 4,
  localparam int BW = $clog2(FW + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      abort,
  input  logic      avail,
  input  logic [W-1:0] data,
  input  par_mode_e par_mode,
  input  logic      two_stop,
  input  logic      tick,
  output logic      load,
  output logic      busy,
  output logic      txd_bit
);

  logic [FW-1:0] frame_q, frame_d, frame_new;
  logic [BW-1:0] left_q, left_d, len_new;
  logic          busy_q, busy_d;
  logic          par_en, par_bit;

  always_comb begin
    par_en  = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
    par_bit = (^data) ^ (par_mode == PAR_ODD);
    frame_new        = '1;
    frame_new[0]     = 1'b0;
    frame_new[W:1]   = data;
    if (par_en) frame_new[W+1] = par_bit;
    len_new = BW'(W + 2) + BW'(par_en) + BW'(two_stop);
  end

  assign load = !busy_q && avail && !abort;

  always_comb begin
    frame_d = frame_q;
    left_d  = left_q;
    busy_d  = busy_q;
    if (abort) begin
      frame_d = '1;
      left_d  = '0;
      busy_d  = 1'b0;
    end else if (load) begin
      frame_d = frame_new;
      left_d  = len_new;
      busy_d  = 1'b1;
    end else if (busy_q && tick) begin
      frame_d = {1'b1, frame_q[FW-1:1]};
      left_d  = left_q - 1'b1;
      if (left_q == BW'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      frame_q <= frame_d;
      left_q  <= left_d;
      busy_q  <= busy_d;
    end
  end

  assign busy    = busy_q;
  assign txd_bit = busy_q ? frame_q[0] : 1'b1;

  // R2: every frame opens with a low start bit
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd_bit);

  // R4: the final bit period of a frame is a high stop bit
  assert_last_bit_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tick && left_q == BW'(1)) |-> txd_bit);

endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int FIFO_DEPTH   = 8,
  parameter int CLKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              txd
);

  localparam int LVL_W = $clog2(FIFO_DEPTH);

  logic [1:0]       rst_pipe;
  logic             rst_n_int;
  ctrl_t            ctrl_q, ctrl_d;
  logic             ovr_q, ovr_d;
  logic             wr_data, wr_stat, wr_ctrl;
  logic             push, pop, full, empty, tick, busy, txd_bit;
  logic             tx_empty;
  logic [DATA_W-1:0] head;
  logic [LVL_W-1:0] level;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);

  assign push = wr_data && !full && !ovr_q && !ctrl_q.brk;

  always_comb begin
    ctrl_d = wr_ctrl ? ctrl_t'(reg_wdata[3:0]) : ctrl_q;
    if (wr_stat) ovr_d = 1'b0;
    else         ovr_d = ovr_q | (wr_data && full && !ctrl_q.brk);
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ctrl_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ovr_q  <= ovr_d;
    end
  end

  sertx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .flush     (ctrl_q.brk),
    .push      (push),
    .push_data (reg_wdata),
    .pop       (pop),
    .pop_data  (head),
    .full      (full),
    .empty     (empty),
    .level     (level)
  );

  sertx_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_baud (
    .clk   (clk),
    .rst_n (rst_n_int),
    .run   (busy),
    .tick  (tick)
  );

  sertx_shifter #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .abort    (ctrl_q.brk),
    .avail    (!empty),
    .data     (head),
    .par_mode (ctrl_q.parity),
    .two_stop (ctrl_q.two_stop),
    .tick     (tick),
    .load     (pop),
    .busy     (busy),
    .txd_bit  (txd_bit)
  );

  assign tx_empty = empty && !busy;
  assign txd      = !ctrl_q.brk && txd_bit;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_STAT:  reg_rdata[2:0]       = {ovr_q, tx_empty, ~full};
      ADDR_CTRL:  reg_rdata[3:0]       = ctrl_q;
      ADDR_LEVEL: reg_rdata[LVL_W-1:0] = level;
      default:    reg_rdata            = '0;
    endcase
  end

  // R6: overrun holds until a status-register write
  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ovr_q && !wr_stat) |=> ovr_q);

  // R5: a data write that meets a full store raises overrun
  assert_full_write_flags_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_data && full && !ctrl_q.brk) |=> ovr_q);

endmodule

// File: tb/sertx_core_bench.sv
`timescale 1ns/1ps
module sertx_core_bench;

  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int P = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    reg_addr;
  logic          reg_wr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic          txd;

  always #4 clk = ~clk;

  sertx_core #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .CLKS_PER_BIT(P)) u_sertx_core (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txd(txd)
  );

  int checks = 0;
  int fails = 0;
  bit mon_en = 1'b0;
  logic [10:0] exp_q[$];   // {two_stop, parity[1:0], data[7:0]}
  logic [1:0]  cur_par = 2'b00;
  logic        cur_two = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic set_ctrl(input logic two, input logic [1:0] par);
    cur_two = two; cur_par = par;
    wr(2'd2, {4'b0, two, par, 1'b0});
  endtask

  // driver: queues the expected frame when the write should be taken
  task automatic send(input logic [7:0] d, input bit accept);
    if (accept) exp_q.push_back({cur_two, cur_par, d});
    wr(2'd0, d);
  endtask

  task automatic wait_idle();
    logic [DW-1:0] v;
    int n;
    n = 0;
    rd(2'd1, v);
    while (!v[1] && n < 2000) begin
      @(negedge clk); n++; rd(2'd1, v);
    end
    repeat (P) @(negedge clk);
  endtask

  // send one character to an idle block and count edges until empty returns
  task automatic timed_send(input logic [7:0] d, input int exp_edges, input string what);
    logic [DW-1:0] v;
    int n;
    send(d, 1'b1);
    n = 1;
    rd(2'd1, v);
    check(v[1] == 1'b0, "R4", "empty drops after write", v[1], 0);
    while (!v[1] && n < 1000) begin
      @(negedge clk); n++; rd(2'd1, v);
    end
    check(n == exp_edges, "R4", what, n, exp_edges);
  endtask

  // monitor: decodes frames on the line and compares with the queue
  logic [10:0] mon_it;
  logic [12:0] mon_bits;
  int          mon_nb;
  bit          mon_ab;
  bit          mon_pe;
  bit          mon_pb;
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && txd === 1'b0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "frame with nothing queued", 1, 0);
          while (txd !== 1'b1) @(negedge clk);
        end else begin
          mon_it = exp_q.pop_front();
          mon_pe = (mon_it[9:8] == 2'b01) || (mon_it[9:8] == 2'b10);
          mon_nb = 1 + DW + (mon_pe ? 1 : 0) + (mon_it[10] ? 2 : 1);
          mon_ab = 1'b0;
          mon_bits = '1;
          repeat (P/2) @(negedge clk);
          mon_bits[0] = txd;
          if (!mon_en) mon_ab = 1'b1;
          for (int k = 1; k < mon_nb; k++) begin
            repeat (P) @(negedge clk);
            mon_bits[k] = txd;
            if (!mon_en) mon_ab = 1'b1;
          end
          if (!mon_ab) begin
            check(mon_bits[0] == 1'b0, "R2", "start bit", mon_bits[0], 0);
            check(mon_bits[8:1] == mon_it[7:0], "R2", "data bits lsb first",
                  mon_bits[8:1], mon_it[7:0]);
            if (mon_pe) begin
              mon_pb = (^mon_it[7:0]) ^ (mon_it[9:8] == 2'b10);
              check(mon_bits[9] == mon_pb, "R3", "parity bit", mon_bits[9], mon_pb);
            end
            check(mon_bits[mon_nb-1] == 1'b1 && (!mon_it[10] || mon_bits[mon_nb-2] == 1'b1),
                  "R4", "stop bits high", mon_bits[mon_nb-1], 1);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    logic [DW-1:0] v;
    logic [DW-1:0] lv;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(txd == 1'b1, "R1", "line idle high", txd, 1);
    rd(2'd1, v); check(v[2:0] == 3'b011, "R1", "status after reset", v[2:0], 3);
    rd(2'd3, v); check(v == 0, "R1", "level after reset", v, 0);
    rd(2'd2, v); check(v == 0, "R1", "control after reset", v, 0);
    rd(2'd0, v); check(v == 0, "R2", "data register reads zero", v, 0);

    mon_en = 1'b1;

    // R2/R4: 8 data, no parity, one stop = 10 bits
    timed_send(8'hA5, 10*P + 2, "frame length 8N1");
    wait_idle();

    // R3/R4: even parity, two stops = 12 bits
    set_ctrl(1'b1, 2'b01);
    rd(2'd2, v); check(v[3:0] == 4'b1010, "R3", "control readback", v[3:0], 10);
    timed_send(8'h3C, 12*P + 2, "frame length 8E2");
    wait_idle();

    // R3 odd parity, two back-to-back characters (R9)
    set_ctrl(1'b0, 2'b10);
    send(8'h81, 1'b1);
    send(8'h7E, 1'b1);
    wait_idle();

    // R3 mode 11 sends no parity: 10 bits
    set_ctrl(1'b0, 2'b11);
    timed_send(8'h55, 10*P + 2, "frame length parity mode 11");
    wait_idle();

    // R7 level count while one character is on the line
    set_ctrl(1'b0, 2'b00);
    send(8'h11, 1'b1);
    send(8'h22, 1'b1);
    send(8'h33, 1'b1);
    rd(2'd3, v); check(v == 2, "R7", "level with two waiting", v, 2);
    rd(2'd1, v); check(v[0] == 1'b1, "R5", "ready while not full", v[0], 1);
    wait_idle();

    // R5/R6/R7/R9: fill, overflow, sticky overrun
    send(8'hA1, 1'b1);
    send(8'hB2, 1'b1);
    send(8'hC3, 1'b1);
    send(8'hD4, 1'b1);
    send(8'hE5, 1'b1);
    rd(2'd1, v); check(v[0] == 1'b0, "R5", "ready low when full", v[0], 0);
    rd(2'd3, v); check(v == 0, "R7", "level wraps to 0 when full", v, 0);
    send(8'hF6, 1'b0);
    rd(2'd1, v); check(v[2] == 1'b1, "R5", "overrun set by full write", v[2], 1);
    lv = '0;
    while (!lv[0]) rd(2'd1, lv);
    send(8'h5A, 1'b0);
    rd(2'd1, v); check(v[2] == 1'b1, "R6", "overrun stays set", v[2], 1);
    rd(2'd3, v); check(v == 3, "R6", "write with overrun set dropped", v, 3);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check(v[2] == 1'b0, "R6", "status write clears overrun", v[2], 0);
    send(8'h69, 1'b1);
    wait_idle();
    check(exp_q.size() == 0, "R9", "all queued characters sent", exp_q.size(), 0);

    // R8 break flushes and holds the line low
    send(8'h01, 1'b1);
    send(8'h02, 1'b1);
    send(8'h03, 1'b1);
    repeat (10) @(negedge clk);
    mon_en = 1'b0;
    exp_q.delete();
    wr(2'd2, 8'h01);
    for (int k = 0; k < 6; k++) begin
      check(txd == 1'b0, "R8", "line low during break", txd, 0);
      @(negedge clk);
    end
    rd(2'd3, v); check(v == 0, "R8", "fifo flushed by break", v, 0);
    rd(2'd1, v); check(v[1:0] == 2'b11, "R8", "empty and ready in break", v[1:0], 3);
    wr(2'd0, 8'h99);
    rd(2'd3, v); check(v == 0, "R8", "write during break dropped", v, 0);
    wr(2'd2, 8'h00);
    repeat (2) @(negedge clk);
    check(txd == 1'b1, "R8", "line high after break", txd, 1);
    mon_en = 1'b1;
    repeat (3*12*P) @(negedge clk);
    rd(2'd1, v); check(v[1] == 1'b1, "R8", "still empty after break", v[1], 1);
    send(8'h42, 1'b1);
    wait_idle();
    check(exp_q.size() == 0, "R9", "post-break character sent", exp_q.size(), 0);

    report();
  end

endmodule